// File: doc/BRIEF.md
# Two-Source ATM Cell Transmit Multiplexer

This block merges whole ATM cells from two byte-wide sources onto one 8-bit transmit path toward a single PHY. The first source is an internal cell generator. The second is a secondary slave port that can carry cells from another device of the same kind or from an external segmentation engine, for example an AAL5 engine. No cell is ever split: once a source wins a cell, all of that cell's bytes are forwarded before the next arbitration decision. Cells are `CELL_BYTES` long, which is 53 by default.

Both input ports are valid/ready streams that also carry a start-of-cell flag. A byte moves across an input when `*_valid` and `*_ready` are both high at a rising clock edge. A source offers a cell by holding its first byte with `*_soc` and `*_valid` high. It must then keep `*_valid` and that byte stable until `*_ready` rises. Within a cell, a source may drop `*_valid` for any number of cycles, and the output stalls with it. Only the source that owns the current cell ever sees `*_ready` high, so the other source receives back-pressure for the whole cell.

On the output side, the PHY reports with `tx_clav` that it can take a whole cell. `tx_clav` is only examined at the decision point; once a cell is granted, it is sent in full. Each accepted byte appears on `tx_data` one cycle after it is accepted, with the strobe `tx_enb` high, and `tx_soc` marks the first byte of each cell. The level `strict_prio` selects the arbitration policy: low gives fair alternation between the sources, high gives the internal source strict priority.

Top module: `cell_tx_mux`

## Requirements
- R1: The output carries exactly `CELL_BYTES` bytes per cell. All bytes of a cell come from one source in their input order, and no byte of another cell comes between them.
- R2: When `strict_prio` is 0 and both sources offer a cell start at a decision, the grant goes to the source that did not win the previous cell. The first such tie after reset goes to the internal source.
- R3: When `strict_prio` is 1, the secondary source is granted only at a decision where the internal source offers no cell start.
- R4: A decision takes place only in an idle cycle in which `tx_clav` is 1. While `tx_clav` is 0, no new cell starts on the output.
- R5: At most one of `int_ready` and `sec_ready` is high in any cycle. A source's ready is high only while that source owns a cell, and both are low in the decision cycle.
- R6: A byte accepted at an input edge appears on `tx_data` with `tx_enb` equal to 1 after the next edge. `tx_soc` is 1 with the first byte of each cell and 0 with every other byte.
- R7: If the owning source drops `*_valid` in mid-cell, `tx_enb` stays 0 for those cycles and the cell is resumed later by the same source. The other source is not granted in the meantime.
- R8: During reset and in the first cycle after it, `tx_enb`, `tx_soc`, `int_ready` and `sec_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strict_prio | input | 1 | 1: internal cells always win; 0: fair alternation |
| int_data | input | DATA_W | Internal source byte |
| int_soc | input | 1 | Internal source start-of-cell flag |
| int_valid | input | 1 | Internal source byte valid |
| int_ready | output | 1 | Internal source byte taken |
| sec_data | input | DATA_W | Secondary source byte |
| sec_soc | input | 1 | Secondary source start-of-cell flag |
| sec_valid | input | 1 | Secondary source byte valid |
| sec_ready | output | 1 | Secondary source byte taken |
| tx_clav | input | 1 | PHY can accept one more cell |
| tx_data | output | DATA_W | Output byte |
| tx_soc | output | 1 | First byte of an output cell |
| tx_enb | output | 1 | Output byte strobe, active high |

## Verification
The bench builds the block with `DATA_W` = 8 and `CELL_BYTES` = 5. Short cells let one scenario hold several back-to-back decisions, which brings within reach a fair tie sequence after reset, a run of strict-priority wins, and a stall inside a cell. Each byte carries its cell tag plus its position in the cell. Any interleaving, loss or reordering of bytes therefore shows up as a data mismatch at the output.

// File: rtl/cell_mux_pkg.sv
package cell_mux_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_SEC = 1'b1} src_e;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/cell_mux_arb.sv
module cell_mux_arb
  import cell_mux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strict_prio,
  input  logic req_int,
  input  logic req_sec,
  input  logic take,
  output logic any_req,
  output src_e win_src
);
  src_e last_win;

  always_comb begin
    any_req = req_int | req_sec;
    if (strict_prio) begin
      win_src = req_int ? SRC_INT : SRC_SEC;
    end else if (req_int && req_sec) begin
      win_src = (last_win == SRC_INT) ? SRC_SEC : SRC_INT;
    end else begin
      win_src = req_int ? SRC_INT : SRC_SEC;
    end
  end

  // R2: reset value makes the first tie go to the internal source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_win <= SRC_SEC;
    else if (take) last_win <= win_src;
  end
endmodule

// File: rtl/cell_mux_seq.sv
module cell_mux_seq
  import cell_mux_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  src_e start_src,
  input  logic beat,
  output logic busy,
  output src_e owner,
  output logic first
);
  localparam int CW = $clog2(CELL_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);

  logic [CW-1:0] cnt;

  assign first = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= SRC_INT;
      cnt   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        owner <= start_src;
      end
    end else if (beat) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_mux_out.sv
module cell_mux_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_soc,
  output logic              tx_enb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_soc  <= 1'b0;
      tx_enb  <= 1'b0;
    end else begin
      tx_enb <= beat;
      tx_soc <= beat & first;
      if (beat) tx_data <= din;
    end
  end
endmodule

// File: rtl/cell_tx_mux.sv
module cell_tx_mux
  import cell_mux_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strict_prio,
  input  logic [DATA_W-1:0] int_data,
  input  logic              int_soc,
  input  logic              int_valid,
  output logic              int_ready,
  input  logic [DATA_W-1:0] sec_data,
  input  logic              sec_soc,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic              tx_clav,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_soc,
  output logic              tx_enb
);
  logic [NUM_SRC-1:0]             s_valid, s_soc, s_ready, s_req;
  logic [NUM_SRC-1:0][DATA_W-1:0] s_data;
  logic busy, first, any_req, take, beat;
  src_e owner, win_src;

  assign s_valid = {sec_valid, int_valid};
  assign s_soc   = {sec_soc, int_soc};
  assign s_data  = {sec_data, int_data};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign s_req[g]   = s_valid[g] & s_soc[g];
    assign s_ready[g] = busy & (owner == src_e'(g));
  end

  assign int_ready = s_ready[SRC_INT];
  assign sec_ready = s_ready[SRC_SEC];
  assign take      = ~busy & tx_clav & any_req;
  assign beat      = |(s_ready & s_valid);

  cell_mux_arb i_arb (
    .clk(clk), .rst_n(rst_n), .strict_prio(strict_prio),
    .req_int(s_req[SRC_INT]), .req_sec(s_req[SRC_SEC]),
    .take(take), .any_req(any_req), .win_src(win_src)
  );

  cell_mux_seq #(.CELL_BYTES(CELL_BYTES)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .start_src(win_src),
    .beat(beat), .busy(busy), .owner(owner), .first(first)
  );

  cell_mux_out #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
    .din(s_data[owner]), .tx_data(tx_data), .tx_soc(tx_soc), .tx_enb(tx_enb)
  );
endmodule

// File: rtl/cell_tx_mux_chk.sv
module cell_tx_mux_chk #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strict_prio,
  input logic              int_soc,
  input logic              int_valid,
  input logic              int_ready,
  input logic              sec_valid,
  input logic              sec_ready,
  input logic              tx_clav,
  input logic              tx_soc,
  input logic              tx_enb
);
  localparam int CW = $clog2(CELL_BYTES + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen <= '0;
    else if (tx_enb) seen <= tx_soc ? CW'(1) : seen + 1'b1;
  end

  AST_CELL_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> (seen == '0 || seen == CW'(CELL_BYTES))); // R1
  AST_CELL_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enb && !tx_soc) |-> (seen != '0 && seen < CW'(CELL_BYTES))); // R1
  AST_STRICT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sec_ready) && $past(strict_prio)) |-> $past(!(int_valid && int_soc))); // R3
  AST_CLAV_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_ready || sec_ready) |-> $past(tx_clav)); // R4
  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ready && sec_ready)); // R5
  AST_ENB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enb |-> $past((int_ready && int_valid) || (sec_ready && sec_valid))); // R6
  AST_SOC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> tx_enb); // R6
endmodule

bind cell_tx_mux cell_tx_mux_chk #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) i_chk (.*);

// File: tb/test_cell_tx_mux.sv
module test_cell_tx_mux;
  localparam int DW = 8;
  localparam int CB = 5;

  logic clk = 1'b0, rst_n = 1'b0, strict_prio = 1'b0, tx_clav = 1'b1;
  logic [DW-1:0] int_data = '0, sec_data = '0, tx_data;
  logic int_soc = 1'b0, int_valid = 1'b0, int_ready;
  logic sec_soc = 1'b0, sec_valid = 1'b0, sec_ready;
  logic tx_soc, tx_enb;

  int checks = 0, fails = 0;
  logic [DW-1:0] hdr_q[$];
  int len_q[$];
  int mon_err = 0, both_ready = 0;

  always #2 clk = ~clk;

  cell_tx_mux #(.DATA_W(DW), .CELL_BYTES(CB)) i_cell_tx_mux (.*);

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && int_ready && sec_ready) both_ready++;
    if (rst_n && tx_enb) begin
      if (tx_soc) begin
        hdr_q.push_back(tx_data);
        len_q.push_back(1);
      end else if (hdr_q.size() == 0) begin
        mon_err++;
      end else begin
        if (tx_data != hdr_q[hdr_q.size()-1] + DW'(len_q[len_q.size()-1])) mon_err++;
        len_q[len_q.size()-1] = len_q[len_q.size()-1] + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    hdr_q.delete(); len_q.delete(); mon_err = 0; both_ready = 0;
  endtask

  task automatic drive_int(input logic [DW-1:0] hdr);
    for (int i = 0; i < CB; i++) begin
      int_data = hdr + DW'(i); int_soc = (i == 0); int_valid = 1'b1;
      forever begin @(negedge clk); if (int_ready) break; end
      @(posedge clk); #1;
    end
    int_valid = 1'b0; int_soc = 1'b0;
  endtask

  task automatic drive_sec(input logic [DW-1:0] hdr, input int bubble_at);
    for (int i = 0; i < CB; i++) begin
      if (i == bubble_at) begin
        sec_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
      end
      sec_data = hdr + DW'(i); sec_soc = (i == 0); sec_valid = 1'b1;
      forever begin @(negedge clk); if (sec_ready) break; end
      @(posedge clk); #1;
    end
    sec_valid = 1'b0; sec_soc = 1'b0;
  endtask

  task automatic check_cells(input string req, input logic [DW-1:0] exp[]);
    chk({req, " cell count"}, hdr_q.size(), exp.size());
    for (int k = 0; k < exp.size() && k < hdr_q.size(); k++) begin
      chk({req, " cell order"}, int'(hdr_q[k]), int'(exp[k]));
      chk("R1 cell length", len_q[k], CB);
    end
    chk("R1/R6 byte content", mon_err, 0);
    chk("R5 single ready", both_ready, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 tx_enb in reset", int'(tx_enb), 0);
    chk("R8 ready in reset", int'(int_ready | sec_ready), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R8 tx_soc after reset", int'(tx_soc), 0);
    chk("R8 ready after reset", int'(int_ready | sec_ready), 0);
  endtask

  task automatic t_fair();
    logic [DW-1:0] exp[] = '{8'h10, 8'h90, 8'h20, 8'hA0};
    clear_mon(); strict_prio = 1'b0;
    fork
      begin drive_int(8'h10); drive_int(8'h20); end
      begin drive_sec(8'h90, -1); drive_sec(8'hA0, -1); end
    join
    repeat (3) @(posedge clk);
    check_cells("R2 fair", exp);
  endtask

  task automatic t_single();
    logic [DW-1:0] exp[] = '{8'h30};
    clear_mon();
    drive_int(8'h30);
    repeat (3) @(posedge clk);
    check_cells("R6 single", exp);
  endtask

  task automatic t_strict();
    logic [DW-1:0] exp[] = '{8'h40, 8'h50, 8'h60, 8'hB0};
    clear_mon(); strict_prio = 1'b1;
    fork
      begin drive_int(8'h40); drive_int(8'h50); drive_int(8'h60); end
      drive_sec(8'hB0, -1);
    join
    repeat (3) @(posedge clk);
    check_cells("R3 strict", exp);
    strict_prio = 1'b0;
  endtask

  task automatic t_clav();
    logic [DW-1:0] exp[] = '{8'h70};
    clear_mon(); tx_clav = 1'b0;
    fork
      drive_int(8'h70);
      begin
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R4 held while clav low", hdr_q.size(), 0);
        chk("R4 ready low while clav low", int'(int_ready), 0);
        tx_clav = 1'b1;
      end
    join
    repeat (3) @(posedge clk);
    check_cells("R4 after clav", exp);
  endtask

  task automatic t_stall();
    logic [DW-1:0] exp[] = '{8'hC0, 8'h18};
    clear_mon();
    fork
      drive_sec(8'hC0, 2);
      begin repeat (3) @(posedge clk); #1; drive_int(8'h18); end
    join
    repeat (3) @(posedge clk);
    check_cells("R7 stall", exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fair();
    t_single();
    t_strict();
    t_clav();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule